// File: doc/BRIEF.md
# Four-Channel PCM Time-Slot Serial Port

This block joins four voice channels to one serial PCM highway clocked by a bit clock. Every channel has its own transmit sync input and its own receive sync input. An external slot generator pulses these inputs, so the generator alone sets where each channel's slot sits in the frame. The block holds no slot numbers. Within its transmit slot a channel sends one 8-bit sample from its parallel input word, most significant bit first, onto the shared serial output. Within its receive slot it shifts in 8 bits from the shared serial input, again most significant bit first. It then hands the byte to the core on its parallel output with a one-cycle strobe.

Each channel lane has two small state machines, one for transmit and one for receive, with the same three states. LANE_IDLE waits for a sync. LANE_ARM is the one-bit wait used in short-sync mode. LANE_SHIFT carries the 8 bits of the slot. The transitions are as follows:
- LANE_IDLE to LANE_ARM on a sampled sync in short mode.
- LANE_IDLE to LANE_SHIFT on a sampled sync rising edge in long mode.
- LANE_ARM to LANE_SHIFT unconditionally.
- LANE_SHIFT to LANE_IDLE after the eighth bit.
- Any state to LANE_IDLE while the channel's standby input is high.

Transmit bits change on the rising clock edge and receive bits are sampled on the falling edge. The serial output has a separate pad enable and an active-low slot indicator. The tri-state pad itself sits outside the block.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, tx_oe is 0, tsc_n is 1, tx_data is 0, every rx_strobe bit is 0 and every rx_word byte is 0x00.
- R2: With long_sync low, a channel whose fsx bit is high at rising edge k drives its MSB on tx_data from edge k+1. It then drives the remaining bits one per clock, 8 bits in all, and releases the line after edge k+9.
- R3: With long_sync high, a rising edge of fsx sampled at rising edge k launches the MSB at edge k itself. The sync held high over later edges does not restart the slot.
- R4: tx_oe is 1 and tsc_n is 0 in exactly the clock periods in which some channel drives a bit. Otherwise tx_oe is 0, tsc_n is 1 and tx_data is 0.
- R5: The transmitted byte is the value of the channel's tx_word slice (bits 8*n+7 down to 8*n for channel n) at the edge where the MSB is launched. Later changes of that slice within the slot do not alter the bits sent.
- R6: With long_sync low, a channel whose fsr bit is high at falling edge j samples rx_line at falling edges j+2 through j+9, MSB first.
- R7: With long_sync high, a rising edge of fsr sampled at falling edge j makes the channel sample rx_line at falling edges j+1 through j+8, MSB first.
- R8: At the first rising edge after the eighth received bit, the channel's rx_word slice takes the assembled byte and its rx_strobe bit is high for exactly one clock. At no other time does the slice change.
- R9: While a channel's pdn bit is high, it neither drives tx_data nor raises tx_oe, and it neither strobes nor changes its rx_word slice. A pdn rising during a slot abandons that slot at the next edge of that path.
- R10: Slots of different channels may follow one another with no gap. tx_oe then stays high across the boundary, and each channel sends its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_sync | input | 1 | Static framing select: 1 long sync, 0 short sync |
| pdn | input | NCH | Per-channel standby, high = standby |
| fsx | input | NCH | Per-channel transmit sync |
| fsr | input | NCH | Per-channel receive sync |
| tx_word | input | NCH*SLOT_W | Per-channel transmit samples from the core, channel n at bits 8n+7..8n |
| rx_line | input | 1 | Serial receive data |
| tx_data | output | 1 | Serial transmit data, 0 when not driven |
| tx_oe | output | 1 | Pad enable for the shared transmit line |
| tsc_n | output | 1 | Active-low slot indicator |
| rx_word | output | NCH*SLOT_W | Per-channel received samples to the core |
| rx_strobe | output | NCH | Per-channel one-cycle strobe for a new rx_word |

## Verification
The checker assumes that the external slot generator never places two channels' transmit slots on the same bit period. This is why it can demand that at most one lane enable is high at a time. It also assumes that every sync and data input changes away from both clock edges and stays put across them. The directed tasks keep to these rules by driving every input one nanosecond after a rising edge and spacing all channel slots apart. The back-to-back test places the second sync exactly eight bits after the first, so the two slots touch without overlapping.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
    typedef enum logic [1:0] {
        LANE_IDLE,
        LANE_ARM,
        LANE_SHIFT
    } lane_state_e;
endpackage

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_slot_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_sync,
    input  logic              pdn,
    input  logic              sync,
    input  logic [SLOT_W-1:0] word,
    output logic              drive,
    output logic              bit_out
);
    localparam int CW = $clog2(SLOT_W);
    localparam logic [CW-1:0] LAST = CW'(SLOT_W - 1);

    lane_state_e      state, nxt;
    logic             sync_q;
    logic [CW-1:0]    cnt;
    logic [SLOT_W-1:0] sh;

    always_comb begin
        nxt = state;
        unique case (state)
            LANE_IDLE: begin
                if (!pdn && sync && !long_sync)
                    nxt = LANE_ARM;
                else if (!pdn && sync && !sync_q && long_sync)
                    nxt = LANE_SHIFT;
            end
            LANE_ARM:   nxt = pdn ? LANE_IDLE : LANE_SHIFT;
            LANE_SHIFT: nxt = (pdn || cnt == LAST) ? LANE_IDLE : LANE_SHIFT;
            default:    nxt = LANE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LANE_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
        end else begin
            sync_q <= sync;
            if (nxt == LANE_SHIFT && state != LANE_SHIFT) begin
                sh  <= word;
                cnt <= '0;
            end else if (state == LANE_SHIFT) begin
                sh  <= {sh[SLOT_W-2:0], 1'b0};
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        drive   = (state == LANE_SHIFT);
        bit_out = sh[SLOT_W-1];
    end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_slot_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_sync,
    input  logic              pdn,
    input  logic              sync,
    input  logic              din,
    output logic [SLOT_W-1:0] word,
    output logic              strobe
);
    localparam int CW = $clog2(SLOT_W);
    localparam logic [CW-1:0] LAST = CW'(SLOT_W - 1);

    lane_state_e       state, nxt;
    logic              sync_q;
    logic [CW-1:0]     cnt;
    logic [SLOT_W-1:0] sh;
    logic [SLOT_W-1:0] byte_q;
    logic              done_tgl;
    logic              seen_tgl;

    always_comb begin
        nxt = state;
        unique case (state)
            LANE_IDLE: begin
                if (!pdn && sync && !long_sync)
                    nxt = LANE_ARM;
                else if (!pdn && sync && !sync_q && long_sync)
                    nxt = LANE_SHIFT;
            end
            LANE_ARM:   nxt = pdn ? LANE_IDLE : LANE_SHIFT;
            LANE_SHIFT: nxt = (pdn || cnt == LAST) ? LANE_IDLE : LANE_SHIFT;
            default:    nxt = LANE_IDLE;
        endcase
    end

    // receive side runs on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= LANE_IDLE;
        else        state <= nxt;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
            byte_q   <= '0;
            done_tgl <= 1'b0;
        end else begin
            sync_q <= sync;
            if (nxt == LANE_SHIFT && state != LANE_SHIFT) begin
                cnt <= '0;
            end else if (state == LANE_SHIFT && !pdn) begin
                sh  <= {sh[SLOT_W-2:0], din};
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    byte_q   <= {sh[SLOT_W-2:0], din};
                    done_tgl <= ~done_tgl;
                end
            end
        end
    end

    // hand the finished byte to the rising-edge core side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_tgl <= 1'b0;
            word     <= '0;
            strobe   <= 1'b0;
        end else if (done_tgl != seen_tgl) begin
            seen_tgl <= done_tgl;
            word     <= byte_q;
            strobe   <= 1'b1;
        end else begin
            strobe   <= 1'b0;
        end
    end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
    parameter int NCH    = 4,
    parameter int SLOT_W = 8
) (
    input  logic                  pclk,
    input  logic                  rst_n,
    input  logic                  long_sync,
    input  logic [NCH-1:0]        pdn,
    input  logic [NCH-1:0]        fsx,
    input  logic [NCH-1:0]        fsr,
    input  logic [NCH*SLOT_W-1:0] tx_word,
    input  logic                  rx_line,
    output logic                  tx_data,
    output logic                  tx_oe,
    output logic                  tsc_n,
    output logic [NCH*SLOT_W-1:0] rx_word,
    output logic [NCH-1:0]        rx_strobe
);
    logic [NCH-1:0] lane_oe;
    logic [NCH-1:0] lane_bit;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        pcm_tx_lane #(.SLOT_W(SLOT_W)) u_tx (
            .clk      (pclk),
            .rst_n    (rst_n),
            .long_sync(long_sync),
            .pdn      (pdn[i]),
            .sync     (fsx[i]),
            .word     (tx_word[i*SLOT_W +: SLOT_W]),
            .drive    (lane_oe[i]),
            .bit_out  (lane_bit[i])
        );
        pcm_rx_lane #(.SLOT_W(SLOT_W)) u_rx (
            .clk      (pclk),
            .rst_n    (rst_n),
            .long_sync(long_sync),
            .pdn      (pdn[i]),
            .sync     (fsr[i]),
            .din      (rx_line),
            .word     (rx_word[i*SLOT_W +: SLOT_W]),
            .strobe   (rx_strobe[i])
        );
    end

    always_comb begin
        tx_oe   = |lane_oe;
        tx_data = |(lane_oe & lane_bit);
        tsc_n   = ~tx_oe;
    end
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
    parameter int NCH    = 4,
    parameter int SLOT_W = 8
) (
    input logic                  pclk,
    input logic                  rst_n,
    input logic [NCH-1:0]        pdn,
    input logic [NCH-1:0]        fsx,
    input logic [NCH-1:0]        lane_oe,
    input logic                  tsc_n,
    input logic [NCH*SLOT_W-1:0] rx_word,
    input logic [NCH-1:0]        rx_strobe
);
    // R10
    no_overlap_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        $onehot0(lane_oe));

    // R2
    tsc_after_sync_chk: assert property (@(posedge pclk) disable iff (!rst_n)
        $fell(tsc_n) |-> ($past(|fsx) || $past(|fsx, 2)));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R9
        standby_quiet_chk: assert property (@(posedge pclk) disable iff (!rst_n)
            pdn[i] |=> !lane_oe[i]);

        // R8
        strobe_single_chk: assert property (@(posedge pclk) disable iff (!rst_n)
            rx_strobe[i] |=> !rx_strobe[i]);

        // R8
        word_hold_chk: assert property (@(posedge pclk) disable iff (!rst_n)
            !$stable(rx_word[i*SLOT_W +: SLOT_W]) |-> rx_strobe[i]);
    end
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.NCH(NCH), .SLOT_W(SLOT_W)) u_chk (
    .pclk     (pclk),
    .rst_n    (rst_n),
    .pdn      (pdn),
    .fsx      (fsx),
    .lane_oe  (lane_oe),
    .tsc_n    (tsc_n),
    .rx_word  (rx_word),
    .rx_strobe(rx_strobe)
);

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;
    localparam int NCH = 4;
    localparam int W   = 8;

    logic              pclk = 1'b0;
    logic              rst_n = 1'b0;
    logic              long_sync = 1'b0;
    logic [NCH-1:0]    pdn = '0;
    logic [NCH-1:0]    fsx = '0;
    logic [NCH-1:0]    fsr = '0;
    logic [NCH*W-1:0]  tx_word = '0;
    logic              rx_line = 1'b0;
    logic              tx_data;
    logic              tx_oe;
    logic              tsc_n;
    logic [NCH*W-1:0]  rx_word;
    logic [NCH-1:0]    rx_strobe;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] rx_exp [NCH];

    pcm_slot_port #(.NCH(NCH), .SLOT_W(W)) uut (
        .pclk(pclk), .rst_n(rst_n), .long_sync(long_sync), .pdn(pdn),
        .fsx(fsx), .fsr(fsr), .tx_word(tx_word), .rx_line(rx_line),
        .tx_data(tx_data), .tx_oe(tx_oe), .tsc_n(tsc_n),
        .rx_word(rx_word), .rx_strobe(rx_strobe)
    );

    always #5 pclk = ~pclk;

    task automatic tick();
        @(posedge pclk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_idle_line(input string req);
        chk(tx_oe == 1'b0 && tsc_n == 1'b1 && tx_data == 1'b0, req,
            {tx_oe, tsc_n, tx_data}, 3'b010);
    endtask

    // R1
    task automatic test_reset();
        chk_idle_line("R1 line");
        chk(rx_strobe == '0, "R1 strobe", rx_strobe, 0);
        chk(rx_word == '0, "R1 word", rx_word[31:0], 0);
    endtask

    // R2 R3 R4 R5 R9 transmit slot on one channel
    task automatic tx_slot(input int ch, input logic [W-1:0] w, input bit lng, input bit en);
        long_sync = lng;
        tx_word[ch*W +: W] = w;
        fsx[ch] = 1'b1;
        tick();
        if (!lng) begin
            fsx[ch] = 1'b0;
            chk_idle_line("R2 arm gap");
            tick();
        end
        for (int b = 0; b < W; b++) begin
            if (en) begin
                chk(tx_oe == 1'b1 && tsc_n == 1'b0, lng ? "R3 enable" : "R4 enable",
                    {tx_oe, tsc_n}, 2'b10);
                chk(tx_data == w[W-1-b], lng ? "R3 bit" : "R2 bit", tx_data, w[W-1-b]);
            end else begin
                chk_idle_line("R9 standby tx");
            end
            if (b == 0) fsx[ch] = 1'b0;
            if (b == 2) tx_word[ch*W +: W] = ~w; // R5 change during slot
            tick();
        end
        chk_idle_line("R4 release");
        tick();
    endtask

    // R6 R7 R8 R9 receive slot on one channel
    task automatic rx_slot(input int ch, input logic [W-1:0] w, input bit lng, input bit upd);
        long_sync = lng;
        fsr[ch] = 1'b1;
        tick();
        if (!lng) begin
            fsr[ch] = 1'b0;
            tick();
        end
        for (int b = 0; b < W; b++) begin
            rx_line = w[W-1-b];
            if (b == W-1)
                chk(rx_strobe[ch] == 1'b0, "R8 early strobe", rx_strobe[ch], 0);
            tick();
            if (b == 0) fsr[ch] = 1'b0;
        end
        rx_line = 1'b0;
        if (upd) rx_exp[ch] = w;
        chk(rx_strobe[ch] == upd, upd ? (lng ? "R7 strobe" : "R6 strobe") : "R9 strobe",
            rx_strobe[ch], upd);
        chk(rx_word[ch*W +: W] == rx_exp[ch], upd ? (lng ? "R7 word" : "R6 word") : "R9 word",
            rx_word[ch*W +: W], rx_exp[ch]);
        tick();
        chk(rx_strobe[ch] == 1'b0, "R8 one cycle", rx_strobe[ch], 0);
        chk(rx_word[ch*W +: W] == rx_exp[ch], "R8 hold", rx_word[ch*W +: W], rx_exp[ch]);
    endtask

    // R10 two short-sync slots with no gap
    task automatic back_to_back(input logic [W-1:0] w0, input logic [W-1:0] w1);
        long_sync = 1'b0;
        tx_word[0 +: W] = w0;
        tx_word[W +: W] = w1;
        for (int k = 0; k < 19; k++) begin
            if (k >= 2 && k < 10) begin
                chk(tx_oe && !tsc_n, "R10 enable first", tx_oe, 1);
                chk(tx_data == w0[W-1-(k-2)], "R10 first bit", tx_data, w0[W-1-(k-2)]);
            end else if (k >= 10 && k < 18) begin
                chk(tx_oe && !tsc_n, "R10 enable second", tx_oe, 1);
                chk(tx_data == w1[W-1-(k-10)], "R10 second bit", tx_data, w1[W-1-(k-10)]);
            end else begin
                chk_idle_line("R10 idle");
            end
            fsx[0] = (k == 0);
            fsx[1] = (k == 8);
            tick();
        end
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) rx_exp[i] = '0;
        repeat (2) @(posedge pclk);
        #2 rst_n = 1'b1;
        tick();
        test_reset();
        tx_slot(0, 8'hA5, 1'b0, 1'b1);
        tx_slot(3, 8'h3C, 1'b1, 1'b1);
        tx_slot(1, 8'h81, 1'b0, 1'b1);
        rx_slot(1, 8'h96, 1'b0, 1'b1);
        rx_slot(2, 8'h5A, 1'b1, 1'b1);
        rx_slot(0, 8'hC3, 1'b0, 1'b1);
        pdn[2] = 1'b1;
        tx_slot(2, 8'hFF, 1'b0, 1'b0);
        rx_slot(2, 8'h0F, 1'b1, 1'b0);
        pdn[2] = 1'b0;
        tick();
        rx_slot(2, 8'h0F, 1'b1, 1'b1);
        back_to_back(8'h6B, 8'hD2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge pclk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule